// File: doc/BRIEF.md
# Line Error Counter Bank with Sticky Status

This block keeps seven 8-bit line-quality event counters and a 12-bit word of sticky status latches. Upstream logic provides one increment strobe for each counter: the framing-pattern error count, the framing-pattern bit error count, the CRC-4 error count, the bipolar violation count, the far-end block error count, the PRBS multiframe count and the PRBS error count. Each latch records that a counter moved. Some counters have a latch that records any increment, some have a latch that records a wrap to zero, and some have both. One further latch records a change in the jitter attenuator's FIFO fill flags.

A host uses a single-cycle register bus to read and preset the counters and to read the latches. The latches are visible at two addresses. One holds the full status word. The other holds a per-source summary. A read of either address clears every latch. An event that arrives during a clearing read is kept. Read data is registered and appears in the cycle after the read strobe, carrying the values from before the clear.

Top module: `err_cnt_status`

## Requirements
- R1: Each counter adds one in every cycle its strobe is high, unless the host writes that counter in the same cycle. It wraps from 0xFF to 0x00. Strobe bits: 0 framing error, 1 framing bit error, 2 CRC-4, 3 bipolar violation, 4 far-end block error, 5 PRBS multiframe, 6 PRBS error.
- R2: An increment-seen latch is set in the cycle after its counter advances.
- R3: A wrap latch is set only when its counter goes from 0xFF to 0x00. An increment that does not wrap leaves it clear.
- R4: Status word bits: 11 framing error increment; 10 framing bit error wrap; 9 framing bit error increment; 8 CRC-4 wrap; 7 CRC-4 increment; 6 bipolar wrap; 5 bipolar increment; 4 far-end wrap; 3 far-end increment; 2 PRBS multiframe wrap; 1 jitter attenuator; 0 PRBS error wrap. The PRBS counters have no increment latch.
- R5: A read of address 5 (status word) or address 6 (summary) clears all twelve latches. rdata shows the value from before the clear in the next cycle. A read of an unmapped address (7) returns 0 and clears nothing.
- R6: If an event arrives in the same cycle as a clearing read, its latch is set after that read.
- R7: Latch bit 1 is set on a 1-to-0 change of near_full or a 0-to-1 change of near_empty. Other flag changes do not set it. The stored previous flag values reset to 0.
- R8: Counter addresses: 0 far-end block error, 1 bipolar, 2 CRC-4, each in the low byte. Address 3 returns {framing bit error, framing error}. Address 4 returns {PRBS error, PRBS multiframe}. The high counter is in bits 15:8.
- R9: A host write presets the addressed counter or counter pair from wdata and sets no latch. If an event arrives in the same cycle, the write takes effect and the event is dropped.
- R10: Summary word: bit k (k = 0..6) is the OR of the latches of source k, and bit 7 is the jitter attenuator latch.
- R11: A synchronous active-high reset clears all counters, latches and rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 7 | Per-counter increment strobes |
| near_full | input | 1 | Jitter attenuator FIFO near-full flag |
| near_empty | input | 1 | Jitter attenuator FIFO near-empty flag |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Host register address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered read data, valid the cycle after rd_en |

## Verification
The assertions assume three things about the inputs: event strobes and the fill flags are synchronous to clk, the flags are held low during reset, and each bus access lasts exactly one cycle. Flags held low during reset match the reset value of the edge detector, so a flag edge seen right after reset agrees with the stored history. The bench drives every input at the falling clock edge and keeps both flags low until reset is released. It pulses the strobes, reads and writes for one cycle each. It predicts every read result from the requirements alone, including the cases where an event coincides with a clearing read or a preset write.

// File: rtl/ecls_pkg.sv
package ecls_pkg;

    localparam int NUM_SRC = 7;
    localparam int ST_W    = 12;

    // strobe / counter indices
    localparam int SRC_FASE = 0;
    localparam int SRC_FASB = 1;
    localparam int SRC_CRC  = 2;
    localparam int SRC_BPV  = 3;
    localparam int SRC_EBIT = 4;
    localparam int SRC_PMF  = 5;
    localparam int SRC_PERR = 6;

    // host address map
    localparam int A_EBIT = 0;
    localparam int A_BPV  = 1;
    localparam int A_CRC  = 2;
    localparam int A_FAS  = 3;
    localparam int A_PRBS = 4;
    localparam int A_STAT = 5;
    localparam int A_SUM  = 6;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_COUNTER,
        RK_STATUS,
        RK_SUMMARY,
        RK_UNMAPPED
    } rd_kind_t;

    function automatic int src_addr(input int s);
        case (s)
            SRC_FASE, SRC_FASB: return A_FAS;
            SRC_CRC:            return A_CRC;
            SRC_BPV:            return A_BPV;
            SRC_EBIT:           return A_EBIT;
            default:            return A_PRBS;
        endcase
    endfunction

    function automatic bit src_high(input int s);
        return (s == SRC_FASB) || (s == SRC_PERR);
    endfunction

endpackage

// File: rtl/ecls_counter.sv
module ecls_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          inc,
    output logic          wrap
);

    // a preset write has priority and swallows a same-cycle event
    assign inc  = evt & ~load;
    assign wrap = inc & (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (evt) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/ecls_flag_edge.sv
module ecls_flag_edge (
    input  logic clk,
    input  logic rst,
    input  logic near_full,
    input  logic near_empty,
    output logic ja_evt
);

    logic prev_full;
    logic prev_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_full  <= 1'b0;
            prev_empty <= 1'b0;
        end else begin
            prev_full  <= near_full;
            prev_empty <= near_empty;
        end
    end

    assign ja_evt = (prev_full & ~near_full) | (~prev_empty & near_empty);

endmodule

// File: rtl/ecls_latch_bank.sv
module ecls_latch_bank #(
    parameter int NL = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] set_vec,
    input  logic          clr,
    output logic [NL-1:0] latch_q
);

    for (genvar b = 0; b < NL; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                latch_q[b] <= 1'b0;
            end else begin
                // a new event wins over the clear
                latch_q[b] <= (latch_q[b] & ~clr) | set_vec[b];
            end
        end
    end

endmodule

// File: rtl/err_cnt_status.sv
module err_cnt_status
    import ecls_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   evt,
    input  logic                 near_full,
    input  logic                 near_empty,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [AW-1:0]        addr,
    input  logic [2*CW-1:0]      wdata,
    output logic [2*CW-1:0]      rdata
);

    localparam int DW    = 2 * CW;
    localparam int SUM_W = NUM_SRC + 1;

    logic [NUM_SRC*CW-1:0] cnt_flat;
    logic [NUM_SRC-1:0]    inc;
    logic [NUM_SRC-1:0]    wrap;
    logic                  ja_evt;
    logic [ST_W-1:0]       set_vec;
    logic [ST_W-1:0]       latch_q;
    logic [SUM_W-1:0]      summary;
    logic [DW-1:0]         rd_mux;
    rd_kind_t              rk;
    logic                  clr;
    logic                  unused_evts;

    // ---------------- counters ----------------
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int GA = src_addr(g);
        localparam bit GH = src_high(g);
        logic          ld;
        logic [CW-1:0] lv;

        assign ld = wr_en && (addr == AW'(GA));
        if (GH) begin : g_hi
            assign lv = wdata[DW-1:CW];
        end else begin : g_lo
            assign lv = wdata[CW-1:0];
        end

        ecls_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt[g]),
            .load     (ld),
            .load_val (lv),
            .cnt      (cnt_flat[g*CW +: CW]),
            .inc      (inc[g]),
            .wrap     (wrap[g])
        );
    end

    ecls_flag_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .near_full  (near_full),
        .near_empty (near_empty),
        .ja_evt     (ja_evt)
    );

    // ---------------- latch set mapping ----------------
    always_comb begin
        set_vec      = '0;
        set_vec[11]  = inc[SRC_FASE];
        set_vec[10]  = wrap[SRC_FASB];
        set_vec[9]   = inc[SRC_FASB];
        set_vec[8]   = wrap[SRC_CRC];
        set_vec[7]   = inc[SRC_CRC];
        set_vec[6]   = wrap[SRC_BPV];
        set_vec[5]   = inc[SRC_BPV];
        set_vec[4]   = wrap[SRC_EBIT];
        set_vec[3]   = inc[SRC_EBIT];
        set_vec[2]   = wrap[SRC_PMF];
        set_vec[1]   = ja_evt;
        set_vec[0]   = wrap[SRC_PERR];
    end

    assign unused_evts = ^{inc[SRC_PMF], inc[SRC_PERR], wrap[SRC_FASE]};

    // ---------------- read decode ----------------
    always_comb begin
        rk = RK_NONE;
        if (rd_en) begin
            unique case (int'(addr))
                A_EBIT, A_BPV, A_CRC, A_FAS, A_PRBS: rk = RK_COUNTER;
                A_STAT:                              rk = RK_STATUS;
                A_SUM:                               rk = RK_SUMMARY;
                default:                             rk = RK_UNMAPPED;
            endcase
        end
    end

    assign clr = (rk == RK_STATUS) || (rk == RK_SUMMARY);

    ecls_latch_bank #(.NL(ST_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr     (clr),
        .latch_q (latch_q)
    );

    // ---------------- summary word ----------------
    always_comb begin
        summary           = '0;
        summary[SRC_FASE] = latch_q[11];
        summary[SRC_FASB] = latch_q[10] | latch_q[9];
        summary[SRC_CRC]  = latch_q[8]  | latch_q[7];
        summary[SRC_BPV]  = latch_q[6]  | latch_q[5];
        summary[SRC_EBIT] = latch_q[4]  | latch_q[3];
        summary[SRC_PMF]  = latch_q[2];
        summary[SRC_PERR] = latch_q[0];
        summary[NUM_SRC]  = latch_q[1];
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_mux = '0;
        case (int'(addr))
            A_EBIT: rd_mux[CW-1:0] = cnt_flat[SRC_EBIT*CW +: CW];
            A_BPV:  rd_mux[CW-1:0] = cnt_flat[SRC_BPV*CW +: CW];
            A_CRC:  rd_mux[CW-1:0] = cnt_flat[SRC_CRC*CW +: CW];
            A_FAS:  rd_mux = {cnt_flat[SRC_FASB*CW +: CW], cnt_flat[SRC_FASE*CW +: CW]};
            A_PRBS: rd_mux = {cnt_flat[SRC_PERR*CW +: CW], cnt_flat[SRC_PMF*CW +: CW]};
            A_STAT: rd_mux[ST_W-1:0] = latch_q;
            A_SUM:  rd_mux[SUM_W-1:0] = summary;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/err_cnt_status_chk.sv
module err_cnt_status_chk
    import ecls_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            evt_bpv,
    input logic            evt_crc,
    input logic            wr_en,
    input logic            rd_en,
    input logic [AW-1:0]   addr,
    input logic [CW-1:0]   wdata_lo,
    input logic            near_full,
    input logic            near_empty,
    input logic [ST_W-1:0] rdata_lo,
    input logic [ST_W-1:0] latch_q,
    input logic [ST_W-1:0] set_vec,
    input logic            clr,
    input logic [CW-1:0]   cnt_bpv,
    input logic [CW-1:0]   cnt_crc,
    input logic [CW-1:0]   cnt_ebit
);

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_bpv && !(wr_en && addr == AW'(A_BPV))) |=> (cnt_bpv == $past(cnt_bpv) + CW'(1)));

    p_ind_set_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_bpv && !(wr_en && addr == AW'(A_BPV))) |=> latch_q[5]);

    p_wrap_set_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_crc && !(wr_en && addr == AW'(A_CRC)) && (&cnt_crc)) |=> (latch_q[8] && cnt_crc == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q[8]) |-> (&$past(cnt_crc)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (latch_q == $past(set_vec)));

    p_pre_clear_data_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(A_STAT)) |=> (rdata_lo == $past(latch_q)));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    p_ja_full_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(near_full)) |=> latch_q[1]);

    p_ja_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(near_empty)) |=> latch_q[1]);

    p_preset_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(A_EBIT)) |=>
            (cnt_ebit == $past(wdata_lo) &&
             latch_q[4:3] == ($past(clr) ? 2'b00 : $past(latch_q[4:3]))));

endmodule

bind err_cnt_status err_cnt_status_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_bpv    (evt[SRC_BPV]),
    .evt_crc    (evt[SRC_CRC]),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata_lo   (wdata[CW-1:0]),
    .near_full  (near_full),
    .near_empty (near_empty),
    .rdata_lo   (rdata[ST_W-1:0]),
    .latch_q    (latch_q),
    .set_vec    (set_vec),
    .clr        (clr),
    .cnt_bpv    (cnt_flat[SRC_BPV*CW +: CW]),
    .cnt_crc    (cnt_flat[SRC_CRC*CW +: CW]),
    .cnt_ebit   (cnt_flat[SRC_EBIT*CW +: CW])
);

// File: tb/sim_err_cnt_status.sv
module sim_err_cnt_status;

    localparam int CW = 8;
    localparam int AW = 3;
    localparam int NS = 7;
    localparam int DW = 2 * CW;

    localparam logic [AW-1:0] AD_EBIT = 3'd0, AD_BPV = 3'd1, AD_CRC = 3'd2, AD_FAS = 3'd3,
                              AD_PRBS = 3'd4, AD_STAT = 3'd5, AD_SUM = 3'd6, AD_NONE = 3'd7;
    localparam logic [NS-1:0] E_FASE = 7'h01, E_FASB = 7'h02, E_CRC = 7'h04, E_BPV = 7'h08,
                              E_EBIT = 7'h10, E_PMF = 7'h20, E_PERR = 7'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] evt = '0;
    logic          near_full = 1'b0;
    logic          near_empty = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    always #5 clk = ~clk;

    err_cnt_status #(.CW(CW), .AW(AW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .near_full  (near_full),
        .near_empty (near_empty),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata)
    );

    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_q = 1'b0;
    logic [DW-1:0] m_exp;
    string         m_tag;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: read data appears one cycle after the strobe
    always @(posedge clk) rd_q <= rd_en;

    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", rdata);
            end else begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                check(m_tag, rdata, m_exp);
            end
        end
    end

    // driver: one bus/event cycle, returns at the next falling edge
    task automatic tick(input logic [NS-1:0] ev, input logic rd, input logic wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] ex, input string tg);
        evt   = ev;
        rd_en = rd;
        wr_en = wr;
        addr  = a;
        wdata = wd;
        if (rd) begin
            exp_q.push_back(ex);
            tag_q.push_back(tg);
        end
        @(negedge clk);
        evt   = '0;
        rd_en = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] ex, input string tg);
        tick('0, 1'b1, 1'b0, a, '0, ex, tg);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] wd);
        tick('0, 1'b0, 1'b1, a, wd, '0, "");
    endtask

    task automatic ev(input logic [NS-1:0] m);
        tick(m, 1'b0, 1'b0, '0, '0, '0, "");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 rdata after reset", rdata, '0);

        // R11: everything starts at zero
        rd(AD_STAT, 16'h0000, "R11 status after reset");
        rd(AD_SUM,  16'h0000, "R11 summary after reset");
        rd(AD_EBIT, 16'h0000, "R11 ebit count");
        rd(AD_BPV,  16'h0000, "R11 bpv count");
        rd(AD_CRC,  16'h0000, "R11 crc count");
        rd(AD_FAS,  16'h0000, "R11 fas pair");
        rd(AD_PRBS, 16'h0000, "R11 prbs pair");

        // R1 / R2: counting and increment latch
        ev(E_BPV); ev(E_BPV); ev(E_BPV);
        rd(AD_BPV,  16'h0003, "R1 bpv counts three");
        rd(AD_STAT, 16'h0020, "R2 bpv increment latch bit5");
        rd(AD_STAT, 16'h0000, "R5 status read cleared latches");

        // R9 / R3 / R10: preset, increment without wrap, wrap
        wr(AD_CRC, 16'h00FE);
        rd(AD_STAT, 16'h0000, "R9 preset sets no latch");
        ev(E_CRC);
        rd(AD_STAT, 16'h0080, "R3 no wrap latch on FE->FF");
        ev(E_CRC);
        rd(AD_SUM,  16'h0004, "R10 summary bit2 for crc");
        rd(AD_STAT, 16'h0000, "R5 summary read cleared latches");
        wr(AD_CRC, 16'h00FF);
        ev(E_CRC);
        rd(AD_STAT, 16'h0180, "R3 crc wrap sets bit8 and bit7");
        rd(AD_CRC,  16'h0000, "R1 crc wrapped to zero");

        // R8: shared address for the framing counters
        wr(AD_FAS, 16'h1234);
        rd(AD_FAS,  16'h1234, "R8 fas pair preset");
        ev(E_FASE);
        rd(AD_FAS,  16'h1235, "R8 framing error in low byte");
        rd(AD_STAT, 16'h0800, "R4 framing error increment bit11");
        wr(AD_FAS, 16'hFF00);
        ev(E_FASB);
        rd(AD_FAS,  16'h0000, "R8 framing bit error wrapped in high byte");
        rd(AD_STAT, 16'h0600, "R4 framing bit error bits10 and 9");
        rd(AD_SUM,  16'h0000, "R5 summary empty after status read");

        // R7: jitter attenuator flag edges
        near_empty = 1'b1; ev('0);
        rd(AD_STAT, 16'h0002, "R7 near_empty rise sets bit1");
        near_empty = 1'b0; ev('0);
        near_full = 1'b1;  ev('0);
        rd(AD_STAT, 16'h0000, "R7 other flag edges ignored");
        near_full = 1'b0;  ev('0);
        rd(AD_STAT, 16'h0002, "R7 near_full fall sets bit1");
        near_empty = 1'b1; ev('0);
        rd(AD_SUM,  16'h0080, "R10 summary bit7 for jitter latch");
        rd(AD_STAT, 16'h0000, "R5 summary read cleared jitter latch");
        near_empty = 1'b0; ev('0);

        // R6: event during a clearing read survives
        tick(E_EBIT, 1'b1, 1'b0, AD_STAT, '0, 16'h0000, "R6 read data is pre-clear value");
        rd(AD_STAT, 16'h0008, "R6 event during clear kept");

        // R9: write wins over same-cycle event
        tick(E_EBIT, 1'b0, 1'b1, AD_EBIT, 16'h0005, '0, "");
        rd(AD_EBIT, 16'h0005, "R9 write wins over event");
        rd(AD_STAT, 16'h0000, "R9 dropped event sets no latch");

        // R4: PRBS counters have wrap latches only
        wr(AD_PRBS, 16'hFFFF);
        ev(E_PMF | E_PERR);
        rd(AD_PRBS, 16'h0000, "R8 prbs pair wrapped");
        rd(AD_STAT, 16'h0005, "R4 prbs wraps bits2 and 0");
        ev(E_PMF); ev(E_PERR);
        rd(AD_STAT, 16'h0000, "R4 prbs increments set no latch");
        rd(AD_PRBS, 16'h0101, "R8 prbs error high, multiframe low");
        wr(AD_EBIT, 16'h00FF);
        ev(E_EBIT);
        rd(AD_STAT, 16'h0018, "R3 far-end wrap bits4 and 3");

        // R10 / R4: all strobes together
        ev(7'h7F);
        rd(AD_SUM,  16'h001F, "R10 summary for all sources");
        ev(7'h7F);
        rd(AD_STAT, 16'h0AA8, "R4 all increment latches");

        // R5: unmapped read neither returns data nor clears
        ev(E_BPV);
        rd(AD_NONE, 16'h0000, "R5 unmapped read returns zero");
        rd(AD_STAT, 16'h0020, "R5 unmapped read did not clear");
        rd(AD_BPV,  16'h0006, "R1 bpv running count");

        // R11: reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(AD_BPV,  16'h0000, "R11 reset clears counter");
        rd(AD_STAT, 16'h0000, "R11 reset clears latches");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule